// File: doc/BRIEF.md
# Multi-Attribute Configuration Register Bank

This block is a small bank of twelve configuration registers reached through a simple synchronous port: an address, write data, a write strobe, a read strobe and registered read data. Each register has a fixed access attribute chosen at compile time. The attributes are constant, plain read/write, set-on-read, event-set with software clear, sticky variants of both, lock-gated writes, hardware self-clearing, first-write-only and write-only with a side-effect pulse.

Hardware inputs let internal events set status bits and clear self-clearing bits. There are two active-low resets. The cold reset returns every register to its default. The warm reset spares only the two sticky registers. Bit 0 of the lock register turns the lockable registers into read-only registers.

Top module: `cfg_attr_bank`

## Requirements
- R1: Address 0 always reads the constant parameter RO_VALUE (default 8'hC3), and writes to it are ignored.
- R2: Address 1 is set-on-read. A read returns the stored value and then sets every bit to 1. A write clears each bit where the write data holds a 1 and leaves bits written 0 unchanged. If a read and a write hit it in the same cycle, the read-set wins.
- R3: Address 2 and the lock register at address 11 are plain read/write registers. Bit 0 of address 11 is the lock.
- R4: At address 3, each bit of hw_set_evt sets the matching bit. A software write of 1 clears a bit and a write of 0 has no effect. When a hardware set and a software clear hit the same bit in the same cycle, the set wins.
- R5: Address 4 (event-set, write-1-clear, set by hw_set_stky) and address 6 (read/write) are sticky. They keep their value through a warm reset and clear only on a cold reset.
- R6: A reset (either input low at a clock edge) clears every non-sticky register to 0 except address 0. It also clears rdata, wo_pulse and wo_data. A cold reset also clears the sticky registers.
- R7: Address 5 accepts writes only while the lock bit is 0. While the lock bit is 1, writes to it are ignored.
- R8: Address 7 stores written data. Each bit of hw_clr_sc clears the matching bit in the next cycle. A write in the same cycle takes precedence over the clear.
- R9: Address 8 behaves like address 7, except that its writes are ignored while the lock bit is 1. Hardware clears through hw_clr_scl still apply while it is locked.
- R10: Address 9 accepts only the first write after a reset of either kind. Later writes are ignored until the next reset.
- R11: Address 10 reads as 0. Each write to it produces wo_pulse high for exactly the next cycle, with wo_data carrying the written value. wo_data holds its value until the next write to address 10.
- R12: rdata changes only in the cycle after rd_en is sampled, and it holds otherwise. It carries the value from before any side effect of the read. Addresses 12 to 15 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Synchronous cold reset, active low; clears everything |
| rst_warm_n | input | 1 | Synchronous warm reset, active low; spares sticky registers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| hw_set_evt | input | DATA_W | Per-bit hardware set for address 3 |
| hw_set_stky | input | DATA_W | Per-bit hardware set for address 4 |
| hw_clr_sc | input | DATA_W | Per-bit hardware clear for address 7 |
| hw_clr_scl | input | DATA_W | Per-bit hardware clear for address 8 |
| wo_pulse | output | 1 | One-cycle pulse after each write to address 10 |
| wo_data | output | DATA_W | Data from the last write to address 10 |

## Verification
Most stored state in this block shows up at the ports only when it is read back. A register left in the wrong state therefore appears in rdata exactly one cycle after the next read of its address, and stays invisible until then. For that reason the bench reads often and compares against its model on every clock.

A wrongly handled lock, write-once flag or sticky register shows up as a stale or unexpected value at the first read after the offending write or reset. A fault in the write-only path shows up directly on wo_pulse and wo_data in the cycle after the write.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;

  typedef enum logic [3:0] {
    AT_RO, AT_RSWC, AT_RW, AT_W1C, AT_W1CS, AT_RWL, AT_RWS,
    AT_SC, AT_SCL, AT_WONCE, AT_WO, AT_LOCK, AT_NONE
  } attr_e;

  localparam int NREG     = 12;
  localparam int IX_RO    = 0;
  localparam int IX_RSWC  = 1;
  localparam int IX_RW    = 2;
  localparam int IX_W1C   = 3;
  localparam int IX_W1CS  = 4;
  localparam int IX_RWL   = 5;
  localparam int IX_RWS   = 6;
  localparam int IX_SC    = 7;
  localparam int IX_SCL   = 8;
  localparam int IX_WONCE = 9;
  localparam int IX_WO    = 10;
  localparam int IX_LOCK  = 11;

  function automatic attr_e attr_of(input int idx);
    case (idx)
      IX_RO:    return AT_RO;
      IX_RSWC:  return AT_RSWC;
      IX_RW:    return AT_RW;
      IX_W1C:   return AT_W1C;
      IX_W1CS:  return AT_W1CS;
      IX_RWL:   return AT_RWL;
      IX_RWS:   return AT_RWS;
      IX_SC:    return AT_SC;
      IX_SCL:   return AT_SCL;
      IX_WONCE: return AT_WONCE;
      IX_WO:    return AT_WO;
      IX_LOCK:  return AT_LOCK;
      default:  return AT_NONE;
    endcase
  endfunction

  // Sticky attributes survive the warm reset
  function automatic bit is_sticky(input attr_e a);
    return (a == AT_W1CS) || (a == AT_RWS);
  endfunction

endpackage

// File: rtl/cab_field.sv
module cab_field #(
  parameter int                  DATA_W  = 8,
  parameter cfg_attr_pkg::attr_e ATTR    = cfg_attr_pkg::AT_RW,
  parameter logic [DATA_W-1:0]   RST_VAL = '0
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  input  logic              lock,
  output logic [DATA_W-1:0] q
);
  import cfg_attr_pkg::*;

  localparam bit STICKY = is_sticky(ATTR);

  logic [DATA_W-1:0] q_r;
  logic              done_r;
  logic              rst_this;

  assign rst_this = cold_rst | (warm_rst & !STICKY);

  function automatic logic [DATA_W-1:0] next_val(
    input logic [DATA_W-1:0] cur,
    input logic              wr,
    input logic [DATA_W-1:0] wd,
    input logic              rd,
    input logic [DATA_W-1:0] set,
    input logic [DATA_W-1:0] clr,
    input logic              lk,
    input logic              done
  );
    logic [DATA_W-1:0] n;
    n = cur;
    case (ATTR)
      AT_RO:   n = RST_VAL;
      AT_RSWC: begin
        if (wr) n = cur & ~wd;
        if (rd) n = '1;
      end
      AT_RW, AT_RWS, AT_LOCK: if (wr) n = wd;
      AT_W1C, AT_W1CS: begin
        if (wr) n = cur & ~wd;
        n = n | set;
      end
      AT_RWL:   if (wr && !lk) n = wd;
      AT_SC:    n = wr ? wd : (cur & ~clr);
      AT_SCL:   n = (wr && !lk) ? wd : (cur & ~clr);
      AT_WONCE: if (wr && !done) n = wd;
      default:  n = '0;
    endcase
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst_this) begin
      q_r    <= RST_VAL;
      done_r <= 1'b0;
    end else begin
      q_r <= next_val(q_r, wr_hit, wdata, rd_hit, hw_set, hw_clr, lock, done_r);
      if (ATTR == AT_WONCE && wr_hit) done_r <= 1'b1;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/cab_rdmux.sv
module cab_rdmux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int NREG   = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NREG-1:0][DATA_W-1:0]  field_q,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) sel = field_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

endmodule

// File: rtl/cfg_attr_bank.sv
module cfg_attr_bank #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [DATA_W-1:0] RO_VALUE = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic              rst_warm_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] hw_set_evt,
  input  logic [DATA_W-1:0] hw_set_stky,
  input  logic [DATA_W-1:0] hw_clr_sc,
  input  logic [DATA_W-1:0] hw_clr_scl,
  output logic              wo_pulse,
  output logic [DATA_W-1:0] wo_data
);
  import cfg_attr_pkg::*;

  localparam int NR = NREG;

  // Named internal events, brought out for the checker
  logic                     cold_rst;
  logic                     warm_rst;
  logic                     lock_on;
  logic                     wo_hit;
  logic [NR-1:0]            wr_hit;
  logic [NR-1:0]            rd_hit;
  logic [NR-1:0][DATA_W-1:0] set_v;
  logic [NR-1:0][DATA_W-1:0] clr_v;
  logic [NR-1:0][DATA_W-1:0] field_q;

  assign cold_rst = !rst_cold_n;
  assign warm_rst = !rst_warm_n | cold_rst;
  assign lock_on  = field_q[IX_LOCK][0];
  assign wo_hit   = wr_en && (addr == ADDR_W'(IX_WO));

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      wr_hit[i] = wr_en && (addr == ADDR_W'(i));
      rd_hit[i] = rd_en && (addr == ADDR_W'(i));
      set_v[i]  = '0;
      clr_v[i]  = '0;
    end
    set_v[IX_W1C]  = hw_set_evt;
    set_v[IX_W1CS] = hw_set_stky;
    clr_v[IX_SC]   = hw_clr_sc;
    clr_v[IX_SCL]  = hw_clr_scl;
  end

  for (genvar i = 0; i < NR; i++) begin : g_fld
    cab_field #(
      .DATA_W (DATA_W),
      .ATTR   (attr_of(i)),
      .RST_VAL((i == IX_RO) ? RO_VALUE : DATA_W'(0))
    ) u_fld (
      .clk     (clk),
      .cold_rst(cold_rst),
      .warm_rst(warm_rst),
      .wr_hit  (wr_hit[i]),
      .rd_hit  (rd_hit[i]),
      .wdata   (wdata),
      .hw_set  (set_v[i]),
      .hw_clr  (clr_v[i]),
      .lock    (lock_on),
      .q       (field_q[i])
    );
  end

  cab_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NR)) u_rd (
    .clk    (clk),
    .rst    (warm_rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .field_q(field_q),
    .rdata  (rdata)
  );

  always_ff @(posedge clk) begin
    if (warm_rst) begin
      wo_pulse <= 1'b0;
      wo_data  <= '0;
    end else begin
      wo_pulse <= wo_hit;
      if (wo_hit) wo_data <= wdata;
    end
  end

endmodule

// File: rtl/cab_checks.sv
module cab_checks #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 4,
  parameter int                NREG     = 12,
  parameter logic [DATA_W-1:0] RO_VALUE = 8'hC3
) (
  input logic                        clk,
  input logic                        rst_cold_n,
  input logic                        rst_warm_n,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [DATA_W-1:0]           rdata,
  input logic [DATA_W-1:0]           hw_set_evt,
  input logic                        wo_pulse,
  input logic [DATA_W-1:0]           wo_data,
  input logic                        lock_on,
  input logic [NREG-1:0][DATA_W-1:0] field_q
);
  import cfg_attr_pkg::*;

  a_r1_ro_value: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (rd_en && addr == ADDR_W'(IX_RO)) |=> (rdata == RO_VALUE));

  a_r2_read_sets: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (rd_en && addr == ADDR_W'(IX_RSWC)) |=> (field_q[IX_RSWC] == '1));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (hw_set_evt != '0) |=> ((field_q[IX_W1C] & $past(hw_set_evt)) == $past(hw_set_evt)));

  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (wr_en && lock_on && addr == ADDR_W'(IX_RWL)) |=> $stable(field_q[IX_RWL]));

  a_r11_wo_pulse: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (wr_en && addr == ADDR_W'(IX_WO)) |=> (wo_pulse && wo_data == $past(wdata)));

  a_r11_wo_quiet: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    !(wr_en && addr == ADDR_W'(IX_WO)) |=> !wo_pulse);

  a_r11_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (rd_en && addr == ADDR_W'(IX_WO)) |=> (rdata == '0));

  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    !rd_en |=> $stable(rdata));

endmodule

bind cfg_attr_bank cab_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NR), .RO_VALUE(RO_VALUE)
) u_chk (
  .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .hw_set_evt(hw_set_evt), .wo_pulse(wo_pulse), .wo_data(wo_data),
  .lock_on(lock_on), .field_q(field_q)
);

// File: tb/sim_cfg_attr_bank.sv
`timescale 1ns/1ps
module sim_cfg_attr_bank;
  localparam int ID = 8'hC3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_cold_n, rst_warm_n, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, hw_set_evt, hw_set_stky, hw_clr_sc, hw_clr_scl;
  wire  [7:0] rdata, wo_data;
  wire        wo_pulse;

  cfg_attr_bank u0 (
    .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hw_set_evt(hw_set_evt), .hw_set_stky(hw_set_stky),
    .hw_clr_sc(hw_clr_sc), .hw_clr_scl(hw_clr_scl),
    .wo_pulse(wo_pulse), .wo_data(wo_data)
  );

  int    checks = 0, errors = 0;
  int    m [0:11];
  bit    once_taken;
  int    exp_rd = 0, exp_wod = 0;
  bit    exp_pulse = 0;
  string rd_tag = "R6";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int a);
    case (a)
      0: return "R1";   1: return "R2";   2: return "R3";   3: return "R4";
      4: return "R5";   5: return "R7";   6: return "R5";   7: return "R8";
      8: return "R9";   9: return "R10"; 10: return "R11"; 11: return "R3";
      default: return "R12";
    endcase
  endfunction

  // Behavioural reference: applied at each rising edge from the inputs held there
  task automatic model_update();
    int a;
    bit lk;
    a = int'(addr);
    if (!rst_cold_n || !rst_warm_n) begin
      for (int i = 0; i < 12; i++)
        if (!rst_cold_n || !(i == 4 || i == 6)) m[i] = 0;
      m[0] = ID; once_taken = 0;
      exp_rd = 0; exp_pulse = 0; exp_wod = 0; rd_tag = "R6";
    end else begin
      if (rd_en) begin
        exp_rd = (a < 12 && a != 10) ? m[a] : 0;
        rd_tag = tag_of(a);
      end
      lk = m[11][0];
      if (wr_en) begin
        case (a)
          1, 3, 4: m[a] = m[a] & ~int'(wdata);
          2, 6, 7, 11: m[a] = wdata;
          5, 8: if (!lk) m[a] = wdata;
          9: if (!once_taken) begin m[9] = wdata; once_taken = 1; end
          default: ;
        endcase
      end
      m[3] = m[3] | hw_set_evt;
      m[4] = m[4] | hw_set_stky;
      if (!(wr_en && a == 7)) m[7] = m[7] & ~int'(hw_clr_sc);
      if (!(wr_en && a == 8 && !lk)) m[8] = m[8] & ~int'(hw_clr_scl);
      if (rd_en && a == 1) m[1] = 255;
      exp_pulse = wr_en && a == 10;
      if (exp_pulse) exp_wod = wdata;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(rd_tag, 32'(rdata), 32'(exp_rd));
    check("R11", 32'(wo_pulse), 32'(exp_pulse));
    check("R11", 32'(wo_data), 32'(exp_wod));
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    hw_set_evt = 0; hw_set_stky = 0; hw_clr_sc = 0; hw_clr_scl = 0;
  endtask

  task automatic wr(input int a, input int d);
    idle(); wr_en = 1; addr = 4'(a); wdata = 8'(d); tick(); idle();
  endtask

  task automatic rd(input int a);
    idle(); rd_en = 1; addr = 4'(a); tick(); idle();
  endtask

  task automatic do_reset(input bit cold);
    idle();
    if (cold) rst_cold_n = 0; else rst_warm_n = 0;
    tick(); tick();
    rst_cold_n = 1; rst_warm_n = 1;
  endtask

  task automatic rd_all();
    for (int a = 0; a < 16; a++) rd(a);
  endtask

  initial begin
    idle();
    rst_cold_n = 0; rst_warm_n = 0;
    tick(); tick();
    rst_cold_n = 1; rst_warm_n = 1;
    rd_all();                                  // R6 reset state, R1 constant
    for (int a = 0; a < 16; a++) wr(a, 8'hA5); // R1 and R12 ignored writes
    rd_all();
    // R2: read returns old then sets; write-1 clears; write-0 keeps
    rd(1); rd(1); wr(1, 8'h0F); rd(1); wr(1, 8'h00); rd(1);
    idle(); rd_en = 1; wr_en = 1; addr = 1; wdata = 8'hFF; tick(); idle(); rd(1);
    // R4: set wins over a same-cycle clear
    wr(3, 8'hFF); rd(3);
    idle(); wr_en = 1; addr = 3; wdata = 8'h81; hw_set_evt = 8'h81; tick(); idle(); rd(3);
    wr(3, 8'h01); rd(3);
    // R5 and R6: sticky across warm reset
    idle(); hw_set_stky = 8'h3C; tick(); idle();
    wr(6, 8'h66); wr(2, 8'h22); wr(9, 8'h12);
    do_reset(0); rd_all();
    // R7 and R9: lock gates writes, hw clear still works
    wr(5, 8'h11); wr(8, 8'hF0); wr(11, 8'h01);
    wr(5, 8'h77); wr(8, 8'h55); rd(5); rd(8);
    idle(); hw_clr_scl = 8'h30; tick(); idle(); rd(8);
    wr(11, 8'h00); wr(5, 8'h77); wr(8, 8'h55); rd(5); rd(8);
    // R8: self-clear, write wins in the same cycle
    wr(7, 8'hFF); idle(); hw_clr_sc = 8'h0F; tick(); idle(); rd(7);
    idle(); wr_en = 1; addr = 7; wdata = 8'hAA; hw_clr_sc = 8'hFF; tick(); idle(); rd(7);
    // R10: write-once
    wr(9, 8'h34); wr(9, 8'h56); rd(9); do_reset(0); wr(9, 8'h78); wr(9, 8'h9A); rd(9);
    // R11: back-to-back writes give two pulses
    wr(10, 8'h5E); wr(10, 8'h6F); rd(10); tick();
    do_reset(1); rd_all();
    // Mixed traffic, compared to the model on every clock
    for (int n = 0; n < 1500; n++) begin
      idle();
      if ($urandom_range(0, 59) == 0) begin
        do_reset($urandom_range(0, 1) == 1);
      end else begin
        wr_en = ($urandom_range(0, 2) == 0);
        rd_en = ($urandom_range(0, 1) == 0);
        addr  = 4'($urandom_range(0, 15));
        wdata = 8'($urandom);
        if ($urandom_range(0, 3) == 0) hw_set_evt  = 8'($urandom);
        if ($urandom_range(0, 5) == 0) hw_set_stky = 8'($urandom);
        if ($urandom_range(0, 3) == 0) hw_clr_sc   = 8'($urandom);
        if ($urandom_range(0, 3) == 0) hw_clr_scl  = 8'($urandom);
        tick();
      end
    end
    idle();
    rd_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule